// File: doc/BRIEF.md
# Debug Memory-Read and Bus-Grant Port

This block sits on the debug side of a small CPU and answers register reads from a debug master. One register address acts as a memory window. Each read of that address fetches a single byte from system memory at the address the program counter points to, and then moves the counter forward by one. A master can therefore stream any number of consecutive bytes by reading the same address over and over. The address is formed in one of two ways. In the 16-bit banked mode an 8-bit base register supplies the top byte. In the 24-bit linear mode the full counter is used.

The block also decides when an external bus master may take the address and data buses. Requests arrive on an active-low pin. If granting is enabled, the block answers on an active-low acknowledge pin, but only once no debug operation is in progress. A memory fetch waiting for its data counts as an operation in progress. While the buses are handed over, new memory-window reads are held back. They resume after the external master lets go. A read-only status register reports the enable setting and whether the buses are currently handed over.

Top module: `dbg_mem_port`

## Requirements
- R1: A read of register address 8'h17 returns the grant enable in bit 7 and, in bit 6, a 1 while the buses are handed over (0 otherwise). Bits 5:0 read 0.
- R2: While `busack_en` is 0, a low `bus_req_n` is ignored: `bus_ack_n` stays high and status bit 6 stays 0.
- R3: While `busack_en` is 1 and the block is idle, a low `bus_req_n` sampled at one rising edge drives `bus_ack_n` low after that edge.
- R4: A grant is never issued while a memory-window fetch is outstanding. With the request already pending, `bus_ack_n` falls on the edge that follows the one that raises `rd_valid` for that fetch.
- R5: A read of register address 8'h20 issues one `mem_req` pulse. It answers with a single `rd_valid` pulse whose `rd_data` is the `mem_rdata` returned with `mem_rvalid`. The counter then advances by one.
- R6: When `linear_mode` is 0, `mem_addr` is {`mbase`, pc[15:0]}. The step wraps within pc[15:0] and leaves pc[23:16] unchanged.
- R7: When `linear_mode` is 1, `mem_addr` is pc[23:0] and the step wraps modulo 2^24.
- R8: Back-to-back reads of address 8'h20 return the bytes at successive addresses, with no change of register address needed.
- R9: While the buses are handed over, a read of 8'h20 raises no `mem_req`. The fetch starts only after `bus_req_n` returns high and `bus_ack_n` has risen.
- R10: A read of any address other than 8'h17 and 8'h20 returns 0 in one cycle and leaves the counter unchanged.
- R11: After reset `bus_ack_n` is high, `mem_req` and `rd_valid` are low, `rd_data` is 0 and the counter is 0.
- R12: A granted bus is taken back on the edge after `bus_req_n` is seen high, or after `busack_en` is seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Debug register address |
| reg_rd | input | 1 | One-cycle read strobe |
| rd_data | output | 8 | Read data |
| rd_valid | output | 1 | One-cycle pulse marking valid rd_data |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 24 | Memory read address |
| mem_rvalid | input | 1 | Memory data valid |
| mem_rdata | input | 8 | Memory data |
| pc_ld | input | 1 | Load the counter |
| pc_ld_val | input | 24 | Value to load |
| mbase | input | 8 | Upper address byte in banked mode |
| linear_mode | input | 1 | 1 = 24-bit linear, 0 = 16-bit banked |
| pc_out | output | 24 | Current counter |
| busack_en | input | 1 | Grant enable |
| bus_req_n | input | 1 | External bus request, active low |
| bus_ack_n | output | 1 | Bus acknowledge, active low |

## Verification
The bench drives the counter across the 16-bit and 24-bit boundaries in both modes. A step that carries into the base byte, or that fails to wrap at 24 bits, shows up as a wrong next address. It raises a bus request in the middle of a slow fetch. A design that grants too early would drop `bus_ack_n` before `rd_valid`. It starts a memory-window read while the bus is handed over. A design that does not hold the read back would raise `mem_req` before the release. It also drops the enable while the bus is granted, which a design that only watched the request pin would keep acknowledging.

// File: rtl/dbg_port_pkg.sv
package dbg_port_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_REQ  = 2'd2,
    ST_WAIT = 2'd3
  } rd_state_e;
endpackage

// File: rtl/dbg_pc_unit.sv
module dbg_pc_unit #(
  parameter int AW    = 24,
  parameter int LOW_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          step,
  input  logic          linear,
  input  logic [AW-LOW_W-1:0] base,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] addr
);
  localparam int HI_W = AW - LOW_W;

  logic [AW-1:0]    pc_q, pc_d;
  logic [LOW_W-1:0] low_inc;
  logic             pc_en;

  assign low_inc = pc_q[LOW_W-1:0] + LOW_W'(1);

  always_comb begin
    pc_en = ld | step;
    pc_d  = pc_q;
    if (ld) begin
      pc_d = ld_val;
    end else if (step) begin
      if (linear) pc_d = pc_q + AW'(1);
      else        pc_d = {pc_q[AW-1:LOW_W], low_inc};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  always_comb begin
    if (linear) addr = pc_q;
    else        addr = {base[HI_W-1:0], pc_q[LOW_W-1:0]};
  end

  assign pc = pc_q;
endmodule

// File: rtl/dbg_bus_arb.sv
module dbg_bus_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic req_n,
  input  logic op_idle,
  output logic granted,
  output logic ack_n
);
  logic grant_q, grant_d;

  always_comb begin
    grant_d = grant_q;
    if (grant_q) begin
      if (req_n || !en) grant_d = 1'b0;
    end else if (en && !req_n && op_idle) begin
      grant_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_q <= 1'b0;
    else        grant_q <= grant_d;
  end

  assign granted = grant_q;
  assign ack_n   = ~grant_q;
endmodule

// File: rtl/dbg_rd_ctrl.sv
module dbg_rd_ctrl
  import dbg_port_pkg::*;
#(
  parameter int              RAW       = 8,
  parameter int              DW        = 8,
  parameter logic [RAW-1:0]  STAT_ADDR = 8'h17,
  parameter logic [RAW-1:0]  MEM_ADDR  = 8'h20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd,
  input  logic [RAW-1:0] addr,
  input  logic           granted,
  input  logic           en,
  input  logic           mem_rvalid,
  input  logic [DW-1:0]  mem_rdata,
  output logic           mem_req,
  output logic [DW-1:0]  rd_data,
  output logic           rd_valid,
  output logic           pc_step,
  output logic           op_idle
);
  rd_state_e      st_q, st_d;
  logic [DW-1:0]  data_q, data_d;
  logic           data_en;
  logic           vld_q, vld_d;
  logic           take;

  assign take = (st_q == ST_IDLE) && rd;

  always_comb begin
    st_d    = st_q;
    data_d  = data_q;
    data_en = 1'b0;
    vld_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (take) begin
          if (addr == MEM_ADDR) begin
            st_d = granted ? ST_HOLD : ST_REQ;
          end else begin
            vld_d   = 1'b1;
            data_en = 1'b1;
            data_d  = (addr == STAT_ADDR) ? {en, granted, (DW-2)'(0)} : '0;
          end
        end
      end
      ST_HOLD: if (!granted) st_d = ST_REQ;
      ST_REQ:  st_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rvalid) begin
          st_d    = ST_IDLE;
          vld_d   = 1'b1;
          data_en = 1'b1;
          data_d  = mem_rdata;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign mem_req  = (st_q == ST_REQ);
  assign pc_step  = (st_q == ST_WAIT) && mem_rvalid;
  assign op_idle  = (st_q == ST_IDLE) && !rd;
  assign rd_data  = data_q;
  assign rd_valid = vld_q;
endmodule

// File: rtl/dbg_mem_port.sv
module dbg_mem_port #(
  parameter int             AW        = 24,
  parameter int             LOW_W     = 16,
  parameter int             DW        = 8,
  parameter int             RAW       = 8,
  parameter logic [RAW-1:0] STAT_ADDR = 8'h17,
  parameter logic [RAW-1:0] MEM_ADDR  = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RAW-1:0]    reg_addr,
  input  logic              reg_rd,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rvalid,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              pc_ld,
  input  logic [AW-1:0]     pc_ld_val,
  input  logic [AW-LOW_W-1:0] mbase,
  input  logic              linear_mode,
  output logic [AW-1:0]     pc_out,
  input  logic              busack_en,
  input  logic              bus_req_n,
  output logic              bus_ack_n
);
  logic granted;
  logic op_idle;
  logic pc_step;

  dbg_rd_ctrl #(
    .RAW(RAW), .DW(DW), .STAT_ADDR(STAT_ADDR), .MEM_ADDR(MEM_ADDR)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .rd(reg_rd), .addr(reg_addr),
    .granted(granted), .en(busack_en),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .rd_data(rd_data), .rd_valid(rd_valid),
    .pc_step(pc_step), .op_idle(op_idle)
  );

  dbg_pc_unit #(.AW(AW), .LOW_W(LOW_W)) pc_i (
    .clk(clk), .rst_n(rst_n), .ld(pc_ld), .ld_val(pc_ld_val),
    .step(pc_step), .linear(linear_mode), .base(mbase),
    .pc(pc_out), .addr(mem_addr)
  );

  dbg_bus_arb arb_i (
    .clk(clk), .rst_n(rst_n), .en(busack_en), .req_n(bus_req_n),
    .op_idle(op_idle), .granted(granted), .ack_n(bus_ack_n)
  );
endmodule

// File: rtl/dbg_mem_port_chk.sv
module dbg_mem_port_chk #(
  parameter int AW    = 24,
  parameter int LOW_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busack_en,
  input logic                bus_ack_n,
  input logic                mem_req,
  input logic                mem_rvalid,
  input logic [AW-1:0]       mem_addr,
  input logic                linear_mode,
  input logic [AW-LOW_W-1:0] mbase,
  input logic                pc_ld,
  input logic [AW-1:0]       pc_out
);
  logic inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          inflight <= 1'b0;
    else if (mem_req)    inflight <= 1'b1;
    else if (mem_rvalid) inflight <= 1'b0;
  end

  AST_ACK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack_n |-> $past(busack_en)); // R2
  AST_NO_GRANT_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack_n |-> !inflight); // R4
  AST_NO_FETCH_WHILE_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> bus_ack_n); // R9
  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !inflight); // R5
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight && mem_rvalid && linear_mode && !pc_ld) |=> pc_out == $past(pc_out) + AW'(1)); // R7
  AST_BANKED_TOP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight && mem_rvalid && !linear_mode && !pc_ld) |=> pc_out[AW-1:LOW_W] == $past(pc_out[AW-1:LOW_W])); // R6
  AST_BANKED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !linear_mode) |-> mem_addr[AW-1:LOW_W] == mbase); // R6
endmodule

bind dbg_mem_port dbg_mem_port_chk #(.AW(AW), .LOW_W(LOW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busack_en(busack_en), .bus_ack_n(bus_ack_n),
  .mem_req(mem_req), .mem_rvalid(mem_rvalid), .mem_addr(mem_addr),
  .linear_mode(linear_mode), .mbase(mbase), .pc_ld(pc_ld), .pc_out(pc_out)
);

// File: tb/dbg_mem_port_tb_top.sv
module dbg_mem_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_rd;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic        mem_rvalid;
  logic [7:0]  mem_rdata;
  logic        pc_ld;
  logic [23:0] pc_ld_val;
  logic [7:0]  mbase;
  logic        linear_mode;
  logic [23:0] pc_out;
  logic        busack_en;
  logic        bus_req_n;
  logic        bus_ack_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [23:0] last_addr;
  int  req_cyc;
  int  rel_cyc;
  bit  ack_in_op;
  bit  req_in_grant;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dbg_mem_port dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .pc_ld(pc_ld), .pc_ld_val(pc_ld_val), .mbase(mbase),
    .linear_mode(linear_mode), .pc_out(pc_out), .busack_en(busack_en),
    .bus_req_n(bus_req_n), .bus_ack_n(bus_ack_n)
  );

  // fields: linear, pc start, base, expected address, expected next pc
  localparam logic [80:0] VEC [0:5] = '{
    {1'b0, 24'h001234, 8'hAB, 24'hAB1234, 24'h001235},
    {1'b0, 24'h12FFFF, 8'h03, 24'h03FFFF, 24'h120000},
    {1'b1, 24'h12FFFF, 8'h03, 24'h12FFFF, 24'h130000},
    {1'b1, 24'hFFFFFF, 8'h77, 24'hFFFFFF, 24'h000000},
    {1'b0, 24'h5A00FF, 8'h00, 24'h0000FF, 24'h5A0100},
    {1'b1, 24'h000000, 8'hFF, 24'h000000, 24'h000001}
  };

  function automatic logic [7:0] memf(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_pc(input logic [23:0] v);
    @(negedge clk);
    pc_ld = 1'b1; pc_ld_val = v;
    @(negedge clk);
    pc_ld = 1'b0;
  endtask

  task automatic rd_op(input logic [7:0] a, input int lat, output logic [7:0] d);
    bit seen = 0;
    bit done = 0;
    int cnt = 0;
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    for (int i = 0; i < 400 && !done; i++) begin
      if (i > 0) @(negedge clk);
      mem_rvalid = 1'b0;
      if (seen && !bus_ack_n) ack_in_op = 1;
      if (rd_valid) begin
        d = rd_data; done = 1;
      end else if (mem_req && !seen) begin
        seen = 1; last_addr = mem_addr; req_cyc = cyc; cnt = 0;
        if (!bus_ack_n) req_in_grant = 1;
      end else if (seen) begin
        cnt++;
        if (cnt == lat) begin
          mem_rvalid = 1'b1; mem_rdata = memf(last_addr);
        end
      end
    end
    if (!done) begin
      d = 8'hXX;
      check("read timeout", 32'd0, 32'd1);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=<20000", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; reg_addr = '0; reg_rd = 1'b0; mem_rvalid = 1'b0;
    mem_rdata = '0; pc_ld = 1'b0; pc_ld_val = '0; mbase = '0;
    linear_mode = 1'b0; busack_en = 1'b0; bus_req_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 ack", {31'd0, bus_ack_n}, 32'd1);
    check("R11 mem_req", {31'd0, mem_req}, 32'd0);
    check("R11 rd_valid", {31'd0, rd_valid}, 32'd0);
    check("R11 rd_data", {24'd0, rd_data}, 32'd0);
    check("R11 pc", {8'd0, pc_out}, 32'd0);
    rst_n = 1'b1;

    // R5 R6 R7: vector table
    foreach (VEC[i]) begin
      linear_mode = VEC[i][80];
      mbase       = VEC[i][55:48];
      load_pc(VEC[i][79:56]);
      rd_op(8'h20, 1 + (i % 3), d);
      check(VEC[i][80] ? "R7 address" : "R6 address", {8'd0, last_addr}, {8'd0, VEC[i][47:24]});
      check("R5 data", {24'd0, d}, {24'd0, memf(VEC[i][47:24])});
      check(VEC[i][80] ? "R7 next pc" : "R6 next pc", {8'd0, pc_out}, {8'd0, VEC[i][23:0]});
    end

    // R8 streaming across the banked wrap
    linear_mode = 1'b0; mbase = 8'h10;
    load_pc(24'h00FFFE);
    for (int k = 0; k < 3; k++) begin
      rd_op(8'h20, 2, d);
      check("R8 stream address", {8'd0, last_addr}, {8'd0, 8'h10, 16'hFFFE + 16'(k)});
      check("R8 stream data", {24'd0, d}, {24'd0, memf({8'h10, 16'hFFFE + 16'(k)})});
    end
    check("R8 final pc", {8'd0, pc_out}, 32'h000001);

    // R10 other addresses
    load_pc(24'h345678);
    rd_op(8'h21, 1, d); check("R10 data 21", {24'd0, d}, 32'd0);
    rd_op(8'h00, 1, d); check("R10 data 00", {24'd0, d}, 32'd0);
    rd_op(8'h16, 1, d); check("R10 data 16", {24'd0, d}, 32'd0);
    check("R10 pc kept", {8'd0, pc_out}, 32'h345678);

    // R2 disabled: request ignored
    busack_en = 1'b0; bus_req_n = 1'b0;
    repeat (6) @(negedge clk);
    check("R2 ack held high", {31'd0, bus_ack_n}, 32'd1);
    rd_op(8'h17, 1, d); check("R2 status", {24'd0, d}, 32'h00);
    bus_req_n = 1'b1;

    // R1 status with enable and no grant
    busack_en = 1'b1;
    rd_op(8'h17, 1, d); check("R1 status enabled", {24'd0, d}, 32'h80);

    // R3 grant timing
    @(negedge clk); bus_req_n = 1'b0;
    @(negedge clk); check("R3 ack low", {31'd0, bus_ack_n}, 32'd0);
    rd_op(8'h17, 1, d); check("R1 status granted", {24'd0, d}, 32'hC0);

    // R12 release by request and by enable
    @(negedge clk); bus_req_n = 1'b1;
    @(negedge clk); check("R12 release on request", {31'd0, bus_ack_n}, 32'd1);
    bus_req_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R3 regrant", {31'd0, bus_ack_n}, 32'd0);
    busack_en = 1'b0;
    @(negedge clk); check("R12 release on enable", {31'd0, bus_ack_n}, 32'd1);
    bus_req_n = 1'b1; busack_en = 1'b1;

    // R4 request during an outstanding fetch
    linear_mode = 1'b1;
    load_pc(24'h000100);
    ack_in_op = 0;
    fork
      rd_op(8'h20, 6, d);
      begin repeat (3) @(negedge clk); bus_req_n = 1'b0; end
    join
    check("R4 no ack during fetch", {31'd0, ack_in_op}, 32'd0);
    check("R4 ack high at rd_valid", {31'd0, bus_ack_n}, 32'd1);
    check("R4 data", {24'd0, d}, {24'd0, memf(24'h000100)});
    @(negedge clk); check("R4 ack after fetch", {31'd0, bus_ack_n}, 32'd0);

    // R9 fetch held off while granted
    req_in_grant = 0; rel_cyc = 0;
    fork
      rd_op(8'h20, 1, d);
      begin repeat (6) @(negedge clk); rel_cyc = cyc; bus_req_n = 1'b1; end
    join
    check("R9 no fetch in grant", {31'd0, req_in_grant}, 32'd0);
    check("R9 fetch after release", {31'd0, req_cyc > rel_cyc}, 32'd1);
    check("R9 data", {24'd0, d}, {24'd0, memf(24'h000101)});
    check("R9 pc", {8'd0, pc_out}, 32'h000102);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule